// File: doc/BRIEF.md
# Display Command Packet Sequencer

This block takes one display command of 1 to 8 bytes and turns it into the series of 16-bit register writes that a parallel-to-serial display bridge needs to send that command as a DSI short or long packet. A command is presented as a byte buffer plus a byte count and is taken in with a single-cycle start strobe. The block captures the command, picks the DSI data type from the byte count, and writes a header word and a word-count word. It then writes the payload packed two bytes per register and a transfer trigger. After that it reads the bridge's transfer-control register until its busy bit clears, or until a bounded number of polls has passed.

All traffic goes out over a simple request/acknowledge register port. A request holds its address, data and direction until the port acknowledges it, and a read's data is returned in the acknowledge cycle. On completion the block raises a one-cycle done pulse. Two status flags, one for a rejected length and one for an exhausted poll, stay valid until the next accepted command.

Top module: `dsi_cmd_packer`

## Requirements
- R1: The first write goes to address 0x0602. Its data is the data type ORed with a packet flag. The data type is 0x05 for a 1-byte command, 0x15 for 2 bytes and 0x39 for 3 to 8 bytes. The flag is 0x1000 for 2 bytes or fewer (short packet) and 0x4000 otherwise (long packet).
- R2: The second write goes to address 0x0604 and carries the byte count for a long packet, or 0 for a short one.
- R3: Next come (n+1)/2 payload writes to 0x0610, 0x0612, 0x0614, and so on. Write k carries byte 2k in bits 7:0 and byte 2k+1 in bits 15:8, where byte i is cmd_bytes[8i+7:8i]. Bits 15:8 are zero when 2k+1 equals n, so buffer bytes at index n or above never reach the port.
- R4: After the payload, the block writes 0x0001 to address 0x0600.
- R5: The block then issues reads (bus_we=0) of address 0x0600. It stops at the first read whose bit 0 is 0. done is high for exactly one cycle, the cycle after that read's acknowledge, with timeout low.
- R6: If POLL_LIMIT reads in a row all return bit 0 = 1, the block issues no further read. done pulses the cycle after the last acknowledge, and timeout is 1.
- R7: A start with a length of 0 or above MAX_BYTES makes no bus request. It gives done=1 and len_err=1 in the next cycle.
- R8: While bus_req is high and bus_ack is low, bus_addr, bus_wdata and bus_we hold steady. Each acknowledge completes exactly one operation.
- R9: A start while a command is in progress is ignored. The operation sequence and the result follow the command captured at acceptance, and later changes to cmd_len or cmd_bytes have no effect.
- R10: After reset, bus_req, done, len_err and timeout are all 0.
- R11: len_err and timeout hold their values until the next accepted start, which clears both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Command start strobe |
| cmd_len | input | LEN_W | Command byte count |
| cmd_bytes | input | 8*MAX_BYTES | Command bytes, byte i at bits 8i+7:8i |
| bus_req | output | 1 | Register operation request |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | 16 | Register address |
| bus_wdata | output | 16 | Register write data |
| bus_ack | input | 1 | Operation accepted / read data valid |
| bus_rdata | input | 16 | Read data, valid with bus_ack on reads |
| done | output | 1 | One-cycle completion pulse |
| len_err | output | 1 | Last command had an illegal length |
| timeout | output | 1 | Last poll ran out without seeing idle |

## Verification
The bench sweeps every encodable length, covering both illegal sides, the short/long boundary between 2 and 3 bytes, and the odd counts where the top half of the last payload word must be zero. A design that leaked the next buffer byte there would show a non-zero high byte, and one that picked the packet flag on the wrong side of the boundary would write the wrong header and word count. Each length is run with busy counts at zero, one below the poll limit and at the limit, which exposes an off-by-one poll bound as an early timeout or an extra read. Acknowledge delays and a mid-command start combined with changed inputs expose a design that advances without an acknowledge or that re-captures a command while busy.

// File: rtl/dcp_pkg.sv
`timescale 1ns/1ps
package dcp_pkg;

    localparam int REG_W = 16;

    localparam logic [REG_W-1:0] ADR_XFER = 16'h0600;
    localparam logic [REG_W-1:0] ADR_HDR  = 16'h0602;
    localparam logic [REG_W-1:0] ADR_WCNT = 16'h0604;
    localparam logic [REG_W-1:0] ADR_PAY  = 16'h0610;

    localparam logic [7:0] DT_SHORT_NOARG = 8'h05;
    localparam logic [7:0] DT_SHORT_ARG   = 8'h15;
    localparam logic [7:0] DT_LONG        = 8'h39;

    localparam logic [REG_W-1:0] FLAG_SHORT = 16'h1000;
    localparam logic [REG_W-1:0] FLAG_LONG  = 16'h4000;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WRITE = 2'd1,
        ST_POLL  = 2'd2
    } dcp_state_e;

    typedef struct packed {
        logic             we;
        logic [REG_W-1:0] addr;
        logic [REG_W-1:0] data;
    } dcp_op_t;

    function automatic logic [REG_W-1:0] hdr_word(input int unsigned n);
        logic [7:0] dt;
        if (n == 1)      dt = DT_SHORT_NOARG;
        else if (n == 2) dt = DT_SHORT_ARG;
        else             dt = DT_LONG;
        return ((n <= 2) ? FLAG_SHORT : FLAG_LONG) | {8'h00, dt};
    endfunction

    function automatic logic [REG_W-1:0] wcnt_word(input int unsigned n);
        return (n <= 2) ? '0 : REG_W'(n);
    endfunction

endpackage

// File: rtl/dcp_op_gen.sv
`timescale 1ns/1ps
module dcp_op_gen
    import dcp_pkg::*;
#(
    parameter int MAX_BYTES = 8,
    parameter int LEN_W     = 4,
    parameter int STEP_W    = 3
) (
    input  logic [STEP_W-1:0]      step,
    input  logic [LEN_W-1:0]       len,
    input  logic [MAX_BYTES*8-1:0] bytes,
    output dcp_op_t                op,
    output logic                   last
);
    localparam int NWORDS = (MAX_BYTES + 1) / 2;

    logic [REG_W-1:0] pay [NWORDS];
    logic [STEP_W-1:0] nwords;

    for (genvar k = 0; k < NWORDS; k++) begin : g_pack
        assign pay[k][7:0] = bytes[16*k +: 8];
        if (2*k + 1 < MAX_BYTES) begin : g_hi
            assign pay[k][15:8] = (2*k + 1 < int'(len)) ? bytes[16*k+8 +: 8] : 8'h00;
        end else begin : g_nohi
            assign pay[k][15:8] = 8'h00;
        end
    end

    assign nwords = STEP_W'((int'(len) + 1) / 2);
    assign last   = (step == nwords + STEP_W'(2));

    always_comb begin
        op      = '0;
        op.we   = 1'b1;
        if (step == STEP_W'(0)) begin
            op.addr = ADR_HDR;
            op.data = hdr_word(int'(len));
        end else if (step == STEP_W'(1)) begin
            op.addr = ADR_WCNT;
            op.data = wcnt_word(int'(len));
        end else if (last) begin
            op.addr = ADR_XFER;
            op.data = 16'h0001;
        end else begin
            op.addr = ADR_PAY + REG_W'(2 * (int'(step) - 2));
            for (int k = 0; k < NWORDS; k++) begin
                if (step == STEP_W'(k + 2)) op.data = pay[k];
            end
        end
    end

endmodule

// File: rtl/dcp_poll_ctr.sv
`timescale 1ns/1ps
module dcp_poll_ctr #(
    parameter int POLL_LIMIT = 100
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic inc,
    output logic at_last
);
    localparam int CNT_W = $clog2(POLL_LIMIT + 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clear) cnt <= '0;
        else if (inc)     cnt <= cnt + CNT_W'(1);
    end

    assign at_last = (cnt == CNT_W'(POLL_LIMIT - 1));

    assert_poll_bound_R6: assert property (@(posedge clk) disable iff (rst)
        inc |-> (cnt < CNT_W'(POLL_LIMIT)));

endmodule

// File: rtl/dcp_seq.sv
`timescale 1ns/1ps
module dcp_seq
    import dcp_pkg::*;
#(
    parameter int STEP_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              len_ok,
    input  logic              bus_ack,
    input  logic              rd_busy,
    input  logic              op_last,
    input  logic              poll_last,
    output dcp_state_e        state,
    output logic [STEP_W-1:0] step,
    output logic              accept,
    output logic              poll_inc,
    output logic              done,
    output logic              len_err,
    output logic              timeout
);
    assign accept   = start && (state == ST_IDLE);
    assign poll_inc = (state == ST_POLL) && bus_ack;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            step    <= '0;
            done    <= 1'b0;
            len_err <= 1'b0;
            timeout <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (state)
                ST_IDLE: if (start) begin
                    len_err <= !len_ok;
                    timeout <= 1'b0;
                    step    <= '0;
                    if (len_ok) state <= ST_WRITE;
                    else        done  <= 1'b1;
                end
                ST_WRITE: if (bus_ack) begin
                    if (op_last) state <= ST_POLL;
                    else         step  <= step + STEP_W'(1);
                end
                ST_POLL: if (bus_ack) begin
                    if (!rd_busy) begin
                        done  <= 1'b1;
                        state <= ST_IDLE;
                    end else if (poll_last) begin
                        done    <= 1'b1;
                        timeout <= 1'b1;
                        state   <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assert_done_single_R5: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_busy_ignores_start_R9: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WRITE && start && !bus_ack) |=> (state == ST_WRITE && $stable(step)));

endmodule

// File: rtl/dsi_cmd_packer.sv
`timescale 1ns/1ps
module dsi_cmd_packer
    import dcp_pkg::*;
#(
    parameter int MAX_BYTES  = 8,
    parameter int LEN_W      = 4,
    parameter int POLL_LIMIT = 100
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   start,
    input  logic [LEN_W-1:0]       cmd_len,
    input  logic [MAX_BYTES*8-1:0] cmd_bytes,
    output logic                   bus_req,
    output logic                   bus_we,
    output logic [15:0]            bus_addr,
    output logic [15:0]            bus_wdata,
    input  logic                   bus_ack,
    input  logic [15:0]            bus_rdata,
    output logic                   done,
    output logic                   len_err,
    output logic                   timeout
);
    localparam int NWORDS = (MAX_BYTES + 1) / 2;
    localparam int STEP_W = $clog2(NWORDS + 3);

    dcp_state_e             state;
    logic [STEP_W-1:0]      step;
    logic                   accept, poll_inc, poll_last, op_last, len_ok;
    logic [LEN_W-1:0]       len_q;
    logic [MAX_BYTES*8-1:0] bytes_q;
    dcp_op_t                wr_op;
    logic                   unused_rd;

    assign len_ok    = (cmd_len != '0) && (int'(cmd_len) <= MAX_BYTES);
    assign unused_rd = ^bus_rdata[15:1];

    always_ff @(posedge clk) begin
        if (rst) begin
            len_q   <= '0;
            bytes_q <= '0;
        end else if (accept) begin
            len_q   <= cmd_len;
            bytes_q <= cmd_bytes;
        end
    end

    dcp_seq #(.STEP_W(STEP_W)) u_seq (
        .clk(clk), .rst(rst), .start(start), .len_ok(len_ok),
        .bus_ack(bus_ack), .rd_busy(bus_rdata[0]), .op_last(op_last),
        .poll_last(poll_last), .state(state), .step(step), .accept(accept),
        .poll_inc(poll_inc), .done(done), .len_err(len_err), .timeout(timeout)
    );

    dcp_op_gen #(.MAX_BYTES(MAX_BYTES), .LEN_W(LEN_W), .STEP_W(STEP_W)) u_gen (
        .step(step), .len(len_q), .bytes(bytes_q), .op(wr_op), .last(op_last)
    );

    dcp_poll_ctr #(.POLL_LIMIT(POLL_LIMIT)) u_poll (
        .clk(clk), .rst(rst), .clear(accept), .inc(poll_inc), .at_last(poll_last)
    );

    assign bus_req   = (state != ST_IDLE);
    assign bus_we    = (state == ST_WRITE);
    assign bus_addr  = (state == ST_WRITE) ? wr_op.addr : ADR_XFER;
    assign bus_wdata = (state == ST_WRITE) ? wr_op.data : '0;

    assert_req_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) && $stable(bus_wdata) && $stable(bus_we)));

    assert_bad_len_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        (start && !bus_req && !len_ok) |=> (!bus_req && done && len_err));

    assert_poll_addr_R5: assert property (@(posedge clk) disable iff (rst)
        (bus_req && !bus_we) |-> (bus_addr == ADR_XFER));

    assert_timeout_cause_R6: assert property (@(posedge clk) disable iff (rst)
        (done && timeout) |-> $past(bus_req && !bus_we && bus_ack && bus_rdata[0]));

endmodule

// File: tb/dsi_cmd_packer_bench.sv
`timescale 1ns/1ps
module dsi_cmd_packer_bench;
    localparam int MAXB = 8;
    localparam int LW   = 4;
    localparam int PL   = 6;

    logic clk = 0, rst = 1, start = 0, bus_ack = 0;
    logic [LW-1:0] cmd_len = '0;
    logic [MAXB*8-1:0] cmd_bytes = '0;
    logic [15:0] bus_rdata = '0;
    logic bus_req, bus_we, done, len_err, timeout;
    logic [15:0] bus_addr, bus_wdata;
    int total = 0, bad = 0;

    always #2.5 clk = ~clk;

    dsi_cmd_packer #(.MAX_BYTES(MAXB), .LEN_W(LW), .POLL_LIMIT(PL)) u_dsi_cmd_packer (
        .clk(clk), .rst(rst), .start(start), .cmd_len(cmd_len), .cmd_bytes(cmd_bytes),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_ack(bus_ack), .bus_rdata(bus_rdata), .done(done), .len_err(len_err),
        .timeout(timeout)
    );

    task automatic chk(input logic ok, input string tag, input logic [47:0] act, input logic [47:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_addr(input int len, input int j);
        int nw = (len + 1) / 2;
        if (j == 0) return 16'h0602;
        if (j == 1) return 16'h0604;
        if (j == nw + 2) return 16'h0600;
        return 16'(16'h0610 + 2 * (j - 2));
    endfunction

    function automatic logic [15:0] exp_data(input int len, input logic [63:0] b, input int j);
        int nw = (len + 1) / 2;
        int k;
        logic [7:0] dt;
        if (j == 0) begin
            dt = (len == 1) ? 8'h05 : (len == 2) ? 8'h15 : 8'h39;
            return ((len <= 2) ? 16'h1000 : 16'h4000) | {8'h00, dt};
        end
        if (j == 1) return (len <= 2) ? 16'h0000 : 16'(len);
        if (j == nw + 2) return 16'h0001;
        k = j - 2;
        return {(2*k + 1 < len) ? b[16*k+8 +: 8] : 8'h00, b[16*k +: 8]};
    endfunction

    task automatic run_cmd(input int len, input logic [63:0] b, input int busy_n,
                           input int wait_n, input bit poke);
        int nw, npoll;
        string tag;
        logic [47:0] act, exp;
        @(negedge clk);
        start = 1; cmd_len = LW'(len); cmd_bytes = b;
        @(negedge clk);
        start = 0; cmd_len = LW'(len + 5); cmd_bytes = ~b;
        if (len == 0 || len > MAXB) begin
            chk(!bus_req && done && len_err, "R7 reject", {45'd0, bus_req, done, len_err}, 48'h3);
            @(negedge clk);
            chk(!bus_req && !done && len_err, "R11 len_err held", {45'd0, bus_req, done, len_err}, 48'h1);
            return;
        end
        chk(!timeout && !len_err && !done, "R11 flags cleared", {45'd0, timeout, len_err, done}, 48'h0);
        nw = (len + 1) / 2 + 3;
        for (int j = 0; j < nw; j++) begin
            for (int w = 0; w <= wait_n; w++) begin
                if (w < wait_n) tag = "R8 hold";
                else if (poke && j > 1) tag = "R9 op";
                else if (j == 0) tag = "R1 header";
                else if (j == 1) tag = "R2 count";
                else if (j == nw - 1) tag = "R4 trigger";
                else tag = "R3 payload";
                act = {bus_req, bus_we, 14'd0, bus_addr, bus_wdata};
                exp = {2'b11, 14'd0, exp_addr(len, j), exp_data(len, b, j)};
                chk(act == exp, tag, act, exp);
                if (w == wait_n) begin
                    bus_ack = 1;
                    if (poke && j == 1) begin start = 1; cmd_len = 1; end
                end
                @(negedge clk);
                bus_ack = 0; start = 0;
            end
        end
        npoll = (busy_n >= PL) ? PL : busy_n + 1;
        for (int p = 0; p < npoll; p++) begin
            act = {bus_req, bus_we, 30'd0, bus_addr};
            exp = {2'b10, 30'd0, 16'h0600};
            chk(act == exp, "R5 poll read", act, exp);
            bus_rdata = (p < busy_n) ? 16'hA5A5 : 16'hFFFE;
            bus_ack = 1;
            @(negedge clk);
            bus_ack = 0;
        end
        tag = (busy_n >= PL) ? "R6 timeout end" : (poke ? "R9 end" : "R5 end");
        act = {44'd0, bus_req, done, timeout, len_err};
        exp = {44'd0, 1'b0, 1'b1, (busy_n >= PL), 1'b0};
        chk(act == exp, tag, act, exp);
        @(negedge clk);
        act = {44'd0, bus_req, done, timeout, len_err};
        exp = {44'd0, 1'b0, 1'b0, (busy_n >= PL), 1'b0};
        chk(act == exp, "R11 flags held / R5 single done", act, exp);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        int busy_set[4];
        logic [63:0] b;
        busy_set[0] = 0; busy_set[1] = 2; busy_set[2] = PL - 1; busy_set[3] = PL;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk(!bus_req && !done && !len_err && !timeout, "R10 reset",
            {44'd0, bus_req, done, len_err, timeout}, 48'h0);
        for (int len = 0; len < (1 << LW); len++) begin
            for (int bi = 0; bi < 4; bi++) begin
                for (int i = 0; i < MAXB; i++)
                    b[8*i +: 8] = 8'((len * 37 + i * 29 + bi * 71) ^ 8'hA5);
                run_cmd(len, b, busy_set[bi], (len + bi) % 3, (len + bi) % 3 == 0);
            end
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule